// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block lets a processor reach PCI configuration space through two registers on its own register bus: an address register, where software selects the target (bus, device, function, register) and sets an enable bit, and a data register. A processor read or write of the data register, with the enable bit set, becomes a single configuration request on a request/acknowledge handshake toward a PCI master. The processor access is stalled until the master acknowledges the request.

The request is tagged type-0 when the bus number is zero and type-1 otherwise. The target bus 0, device 31, function 7, register 0 is the special-cycle encoding, and only writes reach it. With the enable bit clear, the data register does nothing: reads return all ones and writes are dropped, without a stall. A master-abort reported with the acknowledge makes a read return all ones. It also sets a sticky error flag, which software clears by writing a one to it.

Top module: `cfg_xlat`

## Requirements
- R1: After reset the address register reads 0, the error register reads 0, `pciReq` is low and `cpuWait` is low.
- R2: The address register at offset 0xCF8 stores register number in bits 7:2, function in 10:8, device in 15:11, bus in 23:16 and enable in bit 31. Bits 1:0 and 30:24 read back as zero whatever was written.
- R3: With the enable bit clear, an access to the data register at offset 0xCFC raises neither `cpuWait` nor `pciReq`. A read returns 0xFFFFFFFF and a write is dropped.
- R4: A started request presents the latched bus, device, function and register fields. `pciKind` is 0 (type-0) for bus 0 and 1 (type-1) for any other bus.
- R5: With bus 0, device 31, function 7, register 0 enabled, a data write issues a request with `pciKind` 2 (special). A data read issues no request, does not stall and returns 0xFFFFFFFF.
- R6: An enabled data access raises `cpuWait` in its first cycle. `pciReq` rises on the next cycle and stays high, with stable fields, until the cycle in which `pciAck` is high. `cpuWait` is low in that cycle and `pciReq` is low on the cycle after.
- R7: For a data write, `pciWr` is high and `pciWdata` equals the processor write data for the whole request.
- R8: For a data read, `cpuRdata` equals `pciRdata` in the acknowledge cycle.
- R9: If `pciAbort` is high with `pciAck`, a read returns 0xFFFFFFFF. The error register at offset 0xD00 then reads 1 in bit 0.
- R10: Writing 1 to bit 0 of the error register clears it. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Processor access valid, held until `cpuWait` is low |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 12 | Byte offset of the register |
| cpuWdata | input | 32 | Processor write data |
| cpuRdata | output | 32 | Processor read data, valid when `cpuWait` is low |
| cpuWait | output | 1 | Stall for the current processor access |
| pciReq | output | 1 | Configuration request outstanding |
| pciKind | output | 2 | 0 type-0, 1 type-1, 2 special |
| pciWr | output | 1 | Request is a write |
| pciBus | output | 8 | Target bus |
| pciDev | output | 5 | Target device |
| pciFunc | output | 3 | Target function |
| pciReg | output | 6 | Target register number (dword) |
| pciWdata | output | 32 | Write data of the request |
| pciAck | input | 1 | Request completed this cycle |
| pciAbort | input | 1 | Request ended in master-abort (with `pciAck`) |
| pciRdata | input | 32 | Read data (with `pciAck`) |

## Verification
The main function is run over a table of targets: bus 0 against nonzero buses, reads against writes, and acknowledges that arrive at once or after several wait cycles. These separate the type-0 and type-1 tagging and check that the stall tracks the acknowledge rather than a fixed count. Aborted reads are mixed with clean ones to show that all ones come from the abort and not from the data. Directed cases cover the special-cycle address in both directions, the disabled data register, the reserved address bits and the clearing rule of the error flag.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
  localparam int DATA_W = 32;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 6;

  localparam logic [DATA_W-1:0] ADDR_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    KIND_TYPE0   = 2'd0,
    KIND_TYPE1   = 2'd1,
    KIND_SPECIAL = 2'd2
  } cfgKind_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_ADDR = 2'd1,
    RD_DATA = 2'd2,
    RD_ERR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   addrWr;
    logic   errClr;
    logic   errSet;
    logic   reqLoad;
    logic   dataFill;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/cfg_xlat_ctrl.sv
module cfg_xlat_ctrl
  import cfg_xlat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_OFF = 12'hCF8,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'hCFC,
  parameter logic [ADDR_W-1:0] ERR_OFF  = 12'hD00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cfgEn,
  input  logic              isSpecial,
  input  logic              pciAck,
  input  logic              pciAbort,
  output ctlStrobe_t        stb,
  output logic              cpuWait,
  output logic              reqActive
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e state, stateNext;

  logic hitAddr, hitData, hitErr, startOk;

  assign hitAddr = cpuSel && (cpuAddr == ADDR_OFF);
  assign hitData = cpuSel && (cpuAddr == DATA_OFF);
  assign hitErr  = cpuSel && (cpuAddr == ERR_OFF);
  assign startOk = hitData && cfgEn && !(isSpecial && !cpuWr);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    cpuWait   = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startOk) begin
          stb.reqLoad = 1'b1;
          cpuWait     = 1'b1;
          stateNext   = ST_BUSY;
        end else begin
          stb.addrWr = hitAddr && cpuWr;
          stb.errClr = hitErr && cpuWr;
          if (hitAddr)      stb.rdSel = RD_ADDR;
          else if (hitErr)  stb.rdSel = RD_ERR;
          else if (hitData) begin
            stb.rdSel    = RD_DATA;
            stb.dataFill = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        stb.rdSel    = RD_DATA;
        stb.dataFill = pciAbort;
        cpuWait      = !pciAck;
        stb.errSet   = pciAck && pciAbort;
        if (pciAck) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqActive = (state == ST_BUSY);
endmodule

// File: rtl/cfg_xlat_dpath.sv
module cfg_xlat_dpath
  import cfg_xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic               cpuWr,
  input  logic [DATA_W-1:0]  cpuWdata,
  input  logic [DATA_W-1:0]  pciRdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               cfgEn,
  output logic               isSpecial,
  output logic [1:0]         pciKind,
  output logic               pciWr,
  output logic [BUS_W-1:0]   pciBus,
  output logic [DEV_W-1:0]   pciDev,
  output logic [FUNC_W-1:0]  pciFunc,
  output logic [REG_W-1:0]   pciReg,
  output logic [DATA_W-1:0]  pciWdata
);
  logic [DATA_W-1:0] addrReg;
  logic              errFlag;
  logic [BUS_W-1:0]  fBus;
  logic [DEV_W-1:0]  fDev;
  logic [FUNC_W-1:0] fFunc;
  logic [REG_W-1:0]  fReg;
  cfgKind_e          kindNow, kindReg;

  assign fReg  = addrReg[7:2];
  assign fFunc = addrReg[10:8];
  assign fDev  = addrReg[15:11];
  assign fBus  = addrReg[23:16];
  assign cfgEn = addrReg[31];

  assign isSpecial = (fBus == '0) && (fDev == '1) && (fFunc == '1) && (fReg == '0);

  always_comb begin
    if (isSpecial)        kindNow = KIND_SPECIAL;
    else if (fBus == '0)  kindNow = KIND_TYPE0;
    else                  kindNow = KIND_TYPE1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      errFlag <= 1'b0;
    end else begin
      if (stb.addrWr) addrReg <= cpuWdata & ADDR_KEEP;
      if (stb.errSet)                     errFlag <= 1'b1;
      else if (stb.errClr && cpuWdata[0]) errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindReg  <= KIND_TYPE0;
      pciWr    <= 1'b0;
      pciBus   <= '0;
      pciDev   <= '0;
      pciFunc  <= '0;
      pciReg   <= '0;
      pciWdata <= '0;
    end else if (stb.reqLoad) begin
      kindReg  <= kindNow;
      pciWr    <= cpuWr;
      pciBus   <= fBus;
      pciDev   <= fDev;
      pciFunc  <= fFunc;
      pciReg   <= fReg;
      pciWdata <= cpuWdata;
    end
  end

  assign pciKind = kindReg;

  always_comb begin
    case (stb.rdSel)
      RD_ADDR: cpuRdata = addrReg;
      RD_ERR:  cpuRdata = {{(DATA_W-1){1'b0}}, errFlag};
      RD_DATA: cpuRdata = stb.dataFill ? '1 : pciRdata;
      default: cpuRdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_OFF = 12'hCF8,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'hCFC,
  parameter logic [ADDR_W-1:0] ERR_OFF  = 12'hD00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuWait,
  output logic              pciReq,
  output logic [1:0]        pciKind,
  output logic              pciWr,
  output logic [7:0]        pciBus,
  output logic [4:0]        pciDev,
  output logic [2:0]        pciFunc,
  output logic [5:0]        pciReg,
  output logic [31:0]       pciWdata,
  input  logic              pciAck,
  input  logic              pciAbort,
  input  logic [31:0]       pciRdata
);
  ctlStrobe_t stb;
  logic cfgEn, isSpecial;

  cfg_xlat_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_OFF(ADDR_OFF), .DATA_OFF(DATA_OFF), .ERR_OFF(ERR_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cfgEn(cfgEn), .isSpecial(isSpecial), .pciAck(pciAck), .pciAbort(pciAbort),
    .stb(stb), .cpuWait(cpuWait), .reqActive(pciReq)
  );

  cfg_xlat_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWr(cpuWr), .cpuWdata(cpuWdata),
    .pciRdata(pciRdata), .cpuRdata(cpuRdata), .cfgEn(cfgEn), .isSpecial(isSpecial),
    .pciKind(pciKind), .pciWr(pciWr), .pciBus(pciBus), .pciDev(pciDev),
    .pciFunc(pciFunc), .pciReg(pciReg), .pciWdata(pciWdata)
  );
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuSel,
  input logic        cpuWr,
  input logic [31:0] cpuWdata,
  input logic [31:0] cpuRdata,
  input logic        cpuWait,
  input logic        pciReq,
  input logic [1:0]  pciKind,
  input logic        pciWr,
  input logic [7:0]  pciBus,
  input logic [4:0]  pciDev,
  input logic [2:0]  pciFunc,
  input logic [5:0]  pciReg,
  input logic [31:0] pciWdata,
  input logic        pciAck,
  input logic        pciAbort,
  input logic [31:0] pciRdata
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && !pciAck |=> pciReq);
  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciAck |=> !pciReq);
  // R6
  wait_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWait |-> cpuSel);
  // R6
  req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && !pciAck |=> $stable({pciKind, pciWr, pciBus, pciDev, pciFunc, pciReg, pciWdata}));
  // R6
  req_starts_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pciReq && cpuWait |=> pciReq);
  // R4
  type0_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciKind == 2'd0 |-> pciBus == 8'd0);
  // R4
  type1_bus_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciKind == 2'd1 |-> pciBus != 8'd0);
  // R5
  special_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciKind == 2'd2 |-> pciWr);
  // R8
  read_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciAck && !pciAbort && !pciWr |-> cpuRdata == pciRdata);
  // R9
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciAck && pciAbort && !pciWr |-> cpuRdata == 32'hFFFF_FFFF);
  // R6
  ack_ends_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciAck |-> !cpuWait);
endmodule

bind cfg_xlat cfg_xlat_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuWdata(cpuWdata),
  .cpuRdata(cpuRdata), .cpuWait(cpuWait), .pciReq(pciReq), .pciKind(pciKind),
  .pciWr(pciWr), .pciBus(pciBus), .pciDev(pciDev), .pciFunc(pciFunc),
  .pciReg(pciReg), .pciWdata(pciWdata), .pciAck(pciAck), .pciAbort(pciAbort),
  .pciRdata(pciRdata)
);

// File: tb/cfg_xlat_bench.sv
`timescale 1ns/100ps
module cfg_xlat_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuWr = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuWait, pciReq, pciWr;
  logic [1:0]  pciKind;
  logic [7:0]  pciBus;
  logic [4:0]  pciDev;
  logic [2:0]  pciFunc;
  logic [5:0]  pciReg;
  logic [31:0] pciWdata;
  logic        pciAck = 1'b0, pciAbort = 1'b0;
  logic [31:0] pciRdata = '0;

  int checks = 0;
  int errors = 0;

  localparam logic [11:0] A_ADDR = 12'hCF8;
  localparam logic [11:0] A_DATA = 12'hCFC;
  localparam logic [11:0] A_ERR  = 12'hD00;

  always #2.5 clk = ~clk;

  cfg_xlat u_cfg_xlat (.*);

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [5:0]  rg;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] prd;
    logic        abort;
    logic [2:0]  delay;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 5'd3,  3'd0, 6'd4,  1'b0, 32'h0,         32'h1234_5678, 1'b0, 3'd0},
    '{8'h00, 5'd1,  3'd2, 6'd63, 1'b1, 32'hA5A5_0F0F, 32'h0,         1'b0, 3'd2},
    '{8'h07, 5'd31, 3'd7, 6'd0,  1'b0, 32'h0,         32'hCAFE_F00D, 1'b0, 3'd4},
    '{8'hFF, 5'd0,  3'd1, 6'd9,  1'b1, 32'h0000_0001, 32'h0,         1'b0, 3'd1},
    '{8'h02, 5'd5,  3'd3, 6'd1,  1'b0, 32'h0,         32'h0BAD_BEEF, 1'b1, 3'd3},
    '{8'h00, 5'd8,  3'd4, 6'd2,  1'b0, 32'h0,         32'h0000_0000, 1'b0, 3'd7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regAcc(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic w);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = wr; cpuAddr = a; cpuWdata = wd;
    #1;
    rd = cpuRdata; w = cpuWait;
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0;
  endtask

  function automatic logic [31:0] addrWord(input logic en, input logic [7:0] b,
      input logic [4:0] d, input logic [2:0] f, input logic [5:0] r);
    return {en, 7'd0, b, d, f, r, 2'b00};
  endfunction

  task automatic pciCycle(input logic wr, input logic [31:0] wd, input logic [2:0] delay,
                          input logic ab, input logic [31:0] prd,
                          input logic [1:0] expKind, input logic [7:0] b,
                          input logic [4:0] d, input logic [2:0] f, input logic [5:0] r);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = wr; cpuAddr = A_DATA; cpuWdata = wd;
    #1;
    chk("R6 wait in first cycle", {31'd0, cpuWait}, 32'd1);
    chk("R6 no req in first cycle", {31'd0, pciReq}, 32'd0);
    @(negedge clk);
    chk("R6 req raised", {31'd0, pciReq}, 32'd1);
    chk("R4 kind", {30'd0, pciKind}, {30'd0, expKind});
    chk("R4 fields", {8'd0, pciBus, pciDev, pciFunc, pciReg}, {8'd0, b, d, f, r});
    chk("R7 pciWr", {31'd0, pciWr}, {31'd0, wr});
    if (wr) chk("R7 wdata", pciWdata, wd);
    for (int i = 0; i < int'(delay); i++) begin
      @(negedge clk);
      chk("R6 still stalled", {30'd0, cpuWait, pciReq}, 32'd3);
    end
    pciAck = 1'b1; pciAbort = ab; pciRdata = prd;
    #1;
    chk("R6 wait low on ack", {31'd0, cpuWait}, 32'd0);
    if (!wr) chk(ab ? "R9 abort read ones" : "R8 read data", cpuRdata, ab ? 32'hFFFF_FFFF : prd);
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0; pciAck = 1'b0; pciAbort = 1'b0;
    #1;
    chk("R6 req dropped", {31'd0, pciReq}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req low", {30'd0, pciReq, cpuWait}, 32'd0);
    rstN = 1'b1;
    regAcc(1'b0, A_ADDR, 32'h0, rd, w);
    chk("R1 addr reg zero", rd, 32'h0);
    regAcc(1'b0, A_ERR, 32'h0, rd, w);
    chk("R1 err reg zero", rd, 32'h0);

    // main table
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      logic [1:0] ek;
      v = VECS[k];
      ek = (v.bus == 8'd0) ? 2'd0 : 2'd1;
      regAcc(1'b1, A_ADDR, addrWord(1'b1, v.bus, v.dev, v.fn, v.rg), rd, w);
      pciCycle(v.wr, v.wd, v.delay, v.abort, v.prd, ek, v.bus, v.dev, v.fn, v.rg);
    end
    regAcc(1'b0, A_ERR, 32'h0, rd, w);
    chk("R9 error flag set", rd, 32'h1);
    regAcc(1'b1, A_ERR, 32'h0, rd, w);
    regAcc(1'b0, A_ERR, 32'h0, rd, w);
    chk("R10 write 0 keeps flag", rd, 32'h1);
    regAcc(1'b1, A_ERR, 32'h1, rd, w);
    regAcc(1'b0, A_ERR, 32'h0, rd, w);
    chk("R10 write 1 clears flag", rd, 32'h0);

    // R2 reserved bits
    regAcc(1'b1, A_ADDR, 32'hFFFF_FFFF, rd, w);
    regAcc(1'b0, A_ADDR, 32'h0, rd, w);
    chk("R2 readback mask", rd, 32'h80FF_FFFC);
    regAcc(1'b1, A_ADDR, 32'h7F12_3457, rd, w);
    regAcc(1'b0, A_ADDR, 32'h0, rd, w);
    chk("R2 fields kept, enable clear", rd, 32'h0012_3454);

    // R3 disabled data register
    regAcc(1'b0, A_DATA, 32'h0, rd, w);
    chk("R3 disabled read ones", rd, 32'hFFFF_FFFF);
    chk("R3 disabled read no wait", {31'd0, w}, 32'd0);
    chk("R3 disabled read no req", {31'd0, pciReq}, 32'd0);
    regAcc(1'b1, A_DATA, 32'h5555_AAAA, rd, w);
    chk("R3 disabled write no wait", {31'd0, w}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R3 disabled write no req", {31'd0, pciReq}, 32'd0);

    // R5 special cycle
    regAcc(1'b1, A_ADDR, addrWord(1'b1, 8'd0, 5'd31, 3'd7, 6'd0), rd, w);
    regAcc(1'b0, A_DATA, 32'h0, rd, w);
    chk("R5 special read ones", rd, 32'hFFFF_FFFF);
    chk("R5 special read no wait", {31'd0, w}, 32'd0);
    chk("R5 special read no req", {31'd0, pciReq}, 32'd0);
    pciCycle(1'b1, 32'h0000_0042, 3'd1, 1'b0, 32'h0, 2'd2, 8'd0, 5'd31, 3'd7, 6'd0);
    // R4 neighbour of special address stays type-0
    regAcc(1'b1, A_ADDR, addrWord(1'b1, 8'd0, 5'd31, 3'd7, 6'd1), rd, w);
    pciCycle(1'b0, 32'h0, 3'd0, 1'b0, 32'h0F0F_F0F0, 2'd0, 8'd0, 5'd31, 3'd7, 6'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule